// File: doc/BRIEF.md
# Password Unlock Checker

This block keeps a 64-bit protection password as four 16-bit words. It watches a simple write bus for command sequences. A three-write entry sequence switches it into password mode. While in that mode, the block can store any single word, return stored words on reads, compare a presented password during a fixed seven-write unlock sequence, and leave the mode again on a two-write exit sequence.

When the seven writes all arrive in order, the framing codes are correct and every presented word equals the stored word, the `unlocked` output rises. A protection controller uses that output to allow its freeze bit to be cleared. A failed comparison never shows which word was wrong. A lock-flag input, driven by the protection mode logic, hides the password from reads and stops it from being reprogrammed.

All addresses are word addresses compared over the full address width. Command codes are decoded from the low byte of the write data only. Password words are compared over all 16 bits.

Top module: `pwd_unlock`

## Requirements
- R1: Writing 0xAA to 0x555, then 0x55 to 0x2AA, then 0x60 to 0x555 on three consecutive writes enters password mode, starting from the cycle after the third write.
- R2: Any write that breaks the entry sequence returns the entry detector to its first step. Password mode is not entered.
- R3: In password mode with the lock flag low, `rdata` gives the stored word selected by an address of exactly 0 to 3. Every other address, and every address outside password mode, reads 0xFFFF.
- R4: In password mode, a write of 0xA0 (any address) followed by a write to an address of exactly 0 to 3 stores the data in that word. If the second write goes to any other address, nothing is stored. At most one word changes per cycle.
- R5: In password mode, a write of 0x90 (any address) followed by a write of 0x00 leaves the mode. If the 0x90 is followed by any other value, the block stays in the mode.
- R6: The unlock sequence is 0x25 at address 0, 0x03 at address 0, the four words at addresses 0, 1, 2 and 3 in that order, then 0x29 at address 0. When every word matches, `unlocked` is high from the cycle after the 0x29 write.
- R7: If any presented word differs from its stored word, the sequence still runs to the closing write, and `unlocked` does not rise.
- R8: A write with the wrong address or the wrong framing code during the unlock sequence aborts it. That write has no other effect. A new attempt must start again with 0x25.
- R9: While `lock_flag` is high, reads return 0xFFFF and word programming is ignored. The stored words are unchanged once the flag is released.
- R10: After reset, `unlocked` is 0, password mode is off and all four words are 0x0000. Once set, `unlocked` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Word address for writes and reads |
| wdata | input | 16 | Write data |
| lock_flag | input | 1 | Password-mode lock: hides and freezes the password |
| rdata | output | 16 | Read data for `addr` |
| unlocked | output | 1 | Password matched; protection may be released |

## Verification
The unlock comparison is tried with four kinds of input. A fully correct sequence must set `unlocked`. A sequence whose only fault is one wrong password word must complete without unlocking. A sequence with a wrong address in a word step, and one with a wrong framing code, must both abort. A sequence aborted by a 0x90 must not start the exit command. Together these separate a data mismatch, which is silent and runs to completion, from a framing fault, which restarts the sequence, and both of those from success. Entry and programming are tried with broken entry sequences, out-of-range and partial addresses, and programming attempts while `lock_flag` is high. A behavioural model compares `rdata` and `unlocked` on every cycle.

// File: rtl/pwd_unlock_pkg.sv
// Package: shared command codes, fixed bus addresses and mode states.
// Assumes command codes are decoded from the low data byte only.
package pwd_unlock_pkg;

    localparam logic [7:0] CMD_UNLK1   = 8'hAA;
    localparam logic [7:0] CMD_UNLK2   = 8'h55;
    localparam logic [7:0] CMD_ENTRY   = 8'h60;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_EXIT1   = 8'h90;
    localparam logic [7:0] CMD_EXIT2   = 8'h00;
    localparam logic [7:0] CMD_OPEN    = 8'h25;
    localparam logic [7:0] CMD_FRAME   = 8'h03;
    localparam logic [7:0] CMD_CLOSE   = 8'h29;

    localparam int unsigned ADDR_CYC1 = 'h555;
    localparam int unsigned ADDR_CYC2 = 'h2AA;

    typedef enum logic [2:0] {
        M_OFF,
        M_ENT1,
        M_ENT2,
        M_IDLE,
        M_PROG,
        M_EXIT
    } mode_e;

endpackage

// File: rtl/pwd_mode_ctrl.sv
// Mode controller: detects the three-write entry sequence, handles the
// program and exit commands inside password mode, and issues word
// program strobes.
// Assumes: while the unlock sequencer is busy, every write belongs to it
// and is ignored here.
module pwd_mode_ctrl
    import pwd_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_flag,
    input  logic              unl_busy,
    output logic              in_mode,
    output logic              arm_unlock,
    output logic              prog_we,
    output logic [IDX_W-1:0]  prog_idx
);

    mode_e st_q, st_d;

    logic at_c1, at_c2, word_addr;
    assign at_c1     = (addr == ADDR_W'(ADDR_CYC1));
    assign at_c2     = (addr == ADDR_W'(ADDR_CYC2));
    assign word_addr = (addr < ADDR_W'(NWORDS));

    // Next-state and program strobe decode for one accepted write.
    always_comb begin
        st_d    = st_q;
        prog_we = 1'b0;
        if (wr_en && !unl_busy) begin
            case (st_q)
                M_OFF:  if (at_c1 && wdata[7:0] == CMD_UNLK1) st_d = M_ENT1;
                M_ENT1: st_d = (at_c2 && wdata[7:0] == CMD_UNLK2) ? M_ENT2 : M_OFF;
                M_ENT2: st_d = (at_c1 && wdata[7:0] == CMD_ENTRY) ? M_IDLE : M_OFF;
                M_IDLE: begin
                    if (wdata[7:0] == CMD_PROG)       st_d = M_PROG;
                    else if (wdata[7:0] == CMD_EXIT1) st_d = M_EXIT;
                end
                M_PROG: begin
                    prog_we = word_addr && !lock_flag;
                    st_d    = M_IDLE;
                end
                M_EXIT: st_d = (wdata[7:0] == CMD_EXIT2) ? M_OFF : M_IDLE;
                default: st_d = M_OFF;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= M_OFF;
        else        st_q <= st_d;
    end

    assign prog_idx   = addr[IDX_W-1:0];
    assign in_mode    = (st_q == M_IDLE) || (st_q == M_PROG) || (st_q == M_EXIT);
    assign arm_unlock = (st_q == M_IDLE);

    // Mode can only be entered by the closing entry write.
    p_entry_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_mode) |-> $past(wr_en && at_c1 && wdata[7:0] == CMD_ENTRY));

    // Mode can only be left by the second exit write.
    p_exit_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_mode) |-> $past(wr_en && wdata[7:0] == CMD_EXIT2));

endmodule

// File: rtl/pwd_store.sv
// Password store: one register per word, written by the mode controller,
// with the read mux for password readback.
// Assumes: reset clears every word to zero; only full addresses 0..NWORDS-1 read.
module pwd_store #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_we,
    input  logic [IDX_W-1:0]         prog_idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     in_mode,
    input  logic                     lock_flag,
    input  logic [ADDR_W-1:0]        addr,
    output logic [DATA_W-1:0]        rdata,
    output logic [NWORDS*DATA_W-1:0] words
);

    logic [NWORDS-1:0] we_vec;

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        assign we_vec[g] = prog_we && (prog_idx == IDX_W'(g));

        // Hold one password word; load it on its program strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)         word_q <= '0;
            else if (we_vec[g]) word_q <= wdata;
        end

        assign words[g*DATA_W +: DATA_W] = word_q;
    end

    logic rd_hit;
    assign rd_hit = in_mode && !lock_flag && (addr < ADDR_W'(NWORDS));

    // Readback mux: stored word on a hit, all ones otherwise.
    always_comb begin
        rdata = '1;
        if (rd_hit) rdata = words[addr[IDX_W-1:0]*DATA_W +: DATA_W];
    end

    // At most one word is written per cycle.
    p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // Words stay frozen while the lock flag is high.
    p_locked_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_flag) |-> $stable(words));

endmodule

// File: rtl/pwd_unlock_seq.sv
// Unlock sequencer: follows the open, frame, word and close writes. It keeps
// a running match flag and sets the sticky unlocked flag on success.
// Assumes: it is armed only while the mode controller is idle in password mode.
module pwd_unlock_seq
    import pwd_unlock_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    localparam int IDX_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int CLOSE_STEP = NWORDS + 2,
    localparam int STEP_W     = $clog2(CLOSE_STEP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     arm,
    input  logic [NWORDS*DATA_W-1:0] words,
    output logic                     busy,
    output logic                     unlocked
);

    logic [STEP_W-1:0] step_q, step_d;
    logic              match_q, match_d;
    logic              unl_q, set_unl;
    logic [IDX_W-1:0]  idx;
    logic              at_zero;

    assign at_zero = (addr == '0);
    assign idx     = IDX_W'(step_q - STEP_W'(2));

    // Step decode: advance on a correct write, drop to zero on a framing fault.
    always_comb begin
        step_d  = step_q;
        match_d = match_q;
        set_unl = 1'b0;
        if (wr_en) begin
            if (step_q == '0) begin
                if (arm && at_zero && wdata[7:0] == CMD_OPEN) step_d = STEP_W'(1);
            end else if (step_q == STEP_W'(1)) begin
                if (at_zero && wdata[7:0] == CMD_FRAME) begin
                    step_d  = STEP_W'(2);
                    match_d = 1'b1;
                end else begin
                    step_d = '0;
                end
            end else if (step_q < STEP_W'(CLOSE_STEP)) begin
                if (addr == ADDR_W'(idx)) begin
                    match_d = match_q && (wdata == words[idx*DATA_W +: DATA_W]);
                    step_d  = step_q + STEP_W'(1);
                end else begin
                    step_d = '0;
                end
            end else begin
                set_unl = at_zero && wdata[7:0] == CMD_CLOSE && match_q;
                step_d  = '0;
            end
        end
    end

    // Step, match and sticky unlocked registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            match_q <= 1'b0;
            unl_q   <= 1'b0;
        end else begin
            step_q  <= step_d;
            match_q <= match_d;
            if (set_unl) unl_q <= 1'b1;
        end
    end

    assign busy     = (step_q != '0);
    assign unlocked = unl_q;

    // Unlock rises only after a closing write at the last step.
    p_unlock_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && at_zero && wdata[7:0] == CMD_CLOSE
                                  && step_q == STEP_W'(CLOSE_STEP)));

    // A bad frame write restarts the sequence.
    p_frame_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == STEP_W'(1) && wr_en && !(at_zero && wdata[7:0] == CMD_FRAME))
        |=> (step_q == '0));

    // Unlocked holds until reset.
    p_unlock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

endmodule

// File: rtl/pwd_unlock.sv
// Top: password unlock checker. Ties the mode controller, the password store
// and the unlock sequencer to one write bus with a combinational read port.
// Assumes one bus write per cycle and a synchronous active-low reset.
module pwd_unlock #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_flag,
    output logic [DATA_W-1:0] rdata,
    output logic              unlocked
);

    logic                     in_mode, arm_unlock, prog_we, unl_busy;
    logic [IDX_W-1:0]         prog_idx;
    logic [NWORDS*DATA_W-1:0] words;

    pwd_mode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .lock_flag  (lock_flag),
        .unl_busy   (unl_busy),
        .in_mode    (in_mode),
        .arm_unlock (arm_unlock),
        .prog_we    (prog_we),
        .prog_idx   (prog_idx)
    );

    pwd_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_we   (prog_we),
        .prog_idx  (prog_idx),
        .wdata     (wdata),
        .in_mode   (in_mode),
        .lock_flag (lock_flag),
        .addr      (addr),
        .rdata     (rdata),
        .words     (words)
    );

    pwd_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .arm      (arm_unlock),
        .words    (words),
        .busy     (unl_busy),
        .unlocked (unlocked)
    );

endmodule

// File: tb/pwd_unlock_bench.sv
// Bench: directed scenarios, plus a behavioural reference model compared on every clock.
module pwd_unlock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        lock_flag = 1'b0;
    logic [15:0] rdata;
    logic        unlocked;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pwd_unlock u_pwd_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lock_flag(lock_flag), .rdata(rdata), .unlocked(unlocked)
    );

    // Reference model: 0 off, 1/2 entry steps, 3 idle, 4 program, 5 exit.
    int          m_mode;
    int          m_step;
    bit          m_match;
    bit          m_unl;
    logic [15:0] m_pw [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_step = 0; m_match = 0; m_unl = 0;
            m_pw = {16'h0, 16'h0, 16'h0, 16'h0};
        end else if (wr_en) begin
            if (m_step != 0) begin
                if (m_step == 1) begin
                    if (addr == 0 && wdata[7:0] == 8'h03) begin m_step = 2; m_match = 1; end
                    else m_step = 0;
                end else if (m_step <= 5) begin
                    if (addr == 12'(m_step - 2)) begin
                        if (wdata != m_pw[m_step - 2]) m_match = 0;
                        m_step++;
                    end else m_step = 0;
                end else begin
                    if (addr == 0 && wdata[7:0] == 8'h29 && m_match) m_unl = 1;
                    m_step = 0;
                end
            end else begin
                case (m_mode)
                    0: if (addr == 12'h555 && wdata[7:0] == 8'hAA) m_mode = 1;
                    1: m_mode = (addr == 12'h2AA && wdata[7:0] == 8'h55) ? 2 : 0;
                    2: m_mode = (addr == 12'h555 && wdata[7:0] == 8'h60) ? 3 : 0;
                    3: begin
                        if (wdata[7:0] == 8'hA0) m_mode = 4;
                        else if (wdata[7:0] == 8'h90) m_mode = 5;
                        else if (wdata[7:0] == 8'h25 && addr == 0) m_step = 1;
                    end
                    4: begin
                        if (addr < 4 && !lock_flag) m_pw[addr] = wdata;
                        m_mode = 3;
                    end
                    5: m_mode = (wdata[7:0] == 8'h00) ? 0 : 3;
                    default: m_mode = 0;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_rd();
        if (m_mode >= 3 && !lock_flag && addr < 4) return m_pw[addr];
        return 16'hFFFF;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, at the falling edge.
    task automatic cmp_model();
        check("R3 model rdata", rdata, model_rd());
        check("R6 model unlocked", 16'(unlocked), 16'(m_unl));
    endtask

    task automatic wr(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        cmp_model();
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(logic [11:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        cmp_model();
        wr_en = 1'b0; addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic enter();
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0060);
    endtask

    task automatic unlock_seq(logic [15:0] w0, logic [15:0] w1,
                              logic [15:0] w2, logic [15:0] w3);
        wr(0, 16'h25); wr(0, 16'h03);
        wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3);
        wr(0, 16'h29);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R10 reset state
        rd(0, 16'hFFFF, "R10 reset rdata");
        check("R10 reset unlocked", 16'(unlocked), 16'h0);
        // R3 outside mode reads ones
        rd(1, 16'hFFFF, "R3 read outside mode");
        // R2 broken entry: bad third code, then wrong second address
        wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0061);
        rd(0, 16'hFFFF, "R2 bad third write");
        wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h0060);
        rd(0, 16'hFFFF, "R2 bad second address");
        // R1 proper entry: zero words visible
        enter();
        rd(0, 16'h0000, "R1 entered mode");
        // R4 program each word
        wr(12'h7, 16'h00A0); wr(0, 16'h1234);
        wr(12'h0, 16'h00A0); wr(1, 16'hABCD);
        wr(12'h555, 16'h00A0); wr(2, 16'h0F0F);
        wr(12'h3, 16'h00A0); wr(3, 16'h8001);
        rd(0, 16'h1234, "R4 word0");
        rd(1, 16'hABCD, "R4 word1");
        rd(2, 16'h0F0F, "R4 word2");
        rd(3, 16'h8001, "R4 word3");
        // R3 full address required
        rd(12'h004, 16'hFFFF, "R3 addr 4");
        rd(12'h101, 16'hFFFF, "R3 partial addr match");
        // R4 out-of-range program target stores nothing
        wr(0, 16'h00A0); wr(12'h105, 16'h5A5A);
        rd(1, 16'hABCD, "R4 out-of-range program");
        // R7 one wrong word: no unlock, no abort
        unlock_seq(16'h1234, 16'hABCD, 16'h0F0E, 16'h8001);
        rd(0, 16'h1234, "R7 mismatch still in mode");
        check("R7 no unlock on mismatch", 16'(unlocked), 16'h0);
        // R8 wrong word address aborts; later writes are plain commands
        wr(0, 16'h25); wr(0, 16'h03); wr(0, 16'h1234); wr(2, 16'hABCD);
        wr(2, 16'h0F0F); wr(3, 16'h8001); wr(0, 16'h29);
        rd(0, 16'h1234, "R8 abort addr");
        check("R8 no unlock after abort", 16'(unlocked), 16'h0);
        // R8 aborting 0x90 has no effect: following 0x00 must not exit
        wr(0, 16'h25); wr(0, 16'h90); wr(0, 16'h00);
        rd(2, 16'h0F0F, "R8 aborting write ignored");
        // R6 correct unlock, timing on the cycle after the close
        unlock_seq(16'h1234, 16'hABCD, 16'h0F0F, 16'h8001);
        @(negedge clk);
        cmp_model();
        wr_en = 1'b0;
        check("R6 unlocked after close", 16'(unlocked), 16'h1);
        // R5 exit: 0x90 then other stays; 0x90,0x00 leaves
        wr(0, 16'h90); wr(0, 16'h55);
        rd(3, 16'h8001, "R5 stays after 90,55");
        wr(0, 16'h90); wr(0, 16'h00);
        rd(3, 16'hFFFF, "R5 left mode");
        // R9 lock flag hides and freezes the words
        enter();
        @(negedge clk); lock_flag = 1'b1; wr_en = 1'b0;
        rd(0, 16'hFFFF, "R9 locked read");
        wr(0, 16'h00A0); wr(0, 16'h5555);
        @(negedge clk); cmp_model(); wr_en = 1'b0; lock_flag = 1'b0;
        rd(0, 16'h1234, "R9 program ignored");
        // R10 sticky unlocked, then cleared by reset
        check("R10 sticky unlocked", 16'(unlocked), 16'h1);
        do_reset();
        check("R10 unlocked after reset", 16'(unlocked), 16'h0);
        enter();
        rd(0, 16'h0000, "R10 words cleared");
        repeat (3) begin @(negedge clk); cmp_model(); end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule